// File: doc/BRIEF.md
# Prefetch and Write-Posting Sequencer

This block drives an engine that streams data between one external chip-select window and an on-chip FIFO. In read mode it fetches from memory into the FIFO while the FIFO has room. In write mode it drains the FIFO out to memory while the FIFO holds data. Each transfer is a request on the memory port that stays up until the port acknowledges it. The target chip select and the direction are captured when the engine starts, so they cannot change while transfers are in flight.

The engine starts when the enable and the start command are both high. In synchronized mode it also waits for a wait-to-not-wait transition, which is a falling edge, on one of four wait pins. Those pins are asynchronous, so each passes through two flops before its edge is detected.

Apart from the transfers, the block watches the FIFO level against a programmed byte threshold. In read mode it compares the bytes held; in write mode it compares the bytes free. The result drives either a level interrupt or a DMA request. The DMA request stays up until it is acknowledged and is raised again only on a fresh crossing.

Top module: `pfe_ctrl`

## Requirements
- R1: After reset, mem_req, irq and dma_req are 0, cs_index is 0 and mem_write is 0.
- R2: While cfg_enable is 0, no new request is issued. If cfg_enable falls during a transfer, mem_req stays high until mem_ack and then the engine returns to idle and issues nothing more.
- R3: With cfg_sync_start = 0, mem_req rises two clock edges after the first edge that sees cfg_enable and start both high, provided a transfer is possible.
- R4: cfg_write_mode is captured at start and shown on mem_write (0 = read into FIFO, 1 = write out of FIFO). A read transfer is issued only while fifo_level < FIFO_DEPTH. A write transfer is issued only while fifo_level > 0.
- R5: cfg_cs_sel is captured on cs_index at start (value n targets chip select n, 0 to 7) and does not change while the engine is active.
- R6: With cfg_sync_start = 1, transfers begin only after a 1-to-0 transition on wait_pins[cfg_wait_sel] that occurs while armed. Rising edges and edges on other pins do not start it.
- R7: A wait-pin edge that happened before start was raised does not start a synchronized engine.
- R8: In read mode the threshold is crossed when fifo_level >= cfg_threshold.
- R9: In write mode the threshold is crossed when FIFO_DEPTH - fifo_level >= cfg_threshold.
- R10: With cfg_dma_mode = 0, irq equals the crossed condition one clock later, and dma_req stays 0.
- R11: With cfg_dma_mode = 1, dma_req rises one clock after the condition goes from not crossed to crossed. It then holds until dma_ack and is not raised again until the condition drops and crosses again. irq stays 0 in this mode.
- R12: One clock after cfg_enable is 0, irq and dma_req are both 0.
- R13: Once mem_req is high, it and cs_index stay unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_write_mode | input | 1 | 0 read into FIFO, 1 write out of FIFO |
| cfg_sync_start | input | 1 | Wait for a wait-pin edge before starting |
| cfg_wait_sel | input | 2 | Which wait pin arms the synchronized start |
| cfg_cs_sel | input | 3 | Target chip select |
| cfg_dma_mode | input | 1 | 1 DMA request, 0 interrupt |
| cfg_threshold | input | 7 | Threshold in bytes |
| start | input | 1 | Start command (level) |
| wait_pins | input | 4 | Asynchronous wait inputs, 1 = wait |
| fifo_level | input | 7 | Bytes held in the FIFO (0 to FIFO_DEPTH) |
| mem_ack | input | 1 | Memory port completes the transfer |
| dma_ack | input | 1 | DMA controller acknowledge |
| mem_req | output | 1 | Transfer request |
| mem_write | output | 1 | Direction of the request |
| cs_index | output | 3 | Chip select being accessed |
| irq | output | 1 | Threshold interrupt |
| dma_req | output | 1 | Threshold DMA request |

## Verification
The bench goes after start latency and the cases where a transfer must not happen. One case is a full FIFO in read mode; a design that ignored it would overrun the FIFO. Another is an empty FIFO in write mode, where such a design would post garbage. For the synchronized start it applies a stale edge before start, an edge on a pin that is not selected, and a rising edge. A design that latched edges early or decoded the wrong polarity would start too soon. The threshold tests cover the exact boundary in both directions and the zero and full extremes. The DMA tests check that the request is held until acknowledged and is not raised again while the level stays high, which an edge-blind design would get wrong. Disabling in mid-transfer checks that the request is not dropped before its acknowledge.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_XFER = 2'd3
    } pfe_state_e;
endpackage

// File: rtl/pfe_wait_sync.sv
module pfe_wait_sync #(
    parameter int NUM_PINS = 4,
    localparam int SEL_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                fall_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] s1;
        logic [NUM_PINS-1:0] s2;
        logic [NUM_PINS-1:0] s3;
    } sync_t;

    sync_t r_d, r_q;
    logic [NUM_PINS-1:0] fall;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = pins_i;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // wait (1) to not-wait (0) transition, per pin
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_fall
        assign fall[g] = r_q.s3[g] & ~r_q.s2[g];
    end

    assign fall_o = fall[sel_i];
endmodule

// File: rtl/pfe_thresh.sv
module pfe_thresh #(
    parameter int DEPTH = 64,
    parameter int THR_W = 7,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int CMP_W = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             write_mode_i,
    input  logic             dma_mode_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic             dma_ack_i,
    output logic             irq_o,
    output logic             dma_req_o
);
    typedef struct packed {
        logic crossed;
        logic irq;
        logic dma;
    } thr_t;

    thr_t r_d, r_q;
    logic [CMP_W-1:0] fill_w, free_w, avail_w, thr_w;
    logic             crossed;

    always_comb begin
        fill_w  = CMP_W'(level_i);
        free_w  = CMP_W'(DEPTH) - fill_w;
        thr_w   = CMP_W'(thr_i);
        avail_w = write_mode_i ? free_w : fill_w;
        crossed = enable_i && (avail_w >= thr_w);

        r_d         = r_q;
        r_d.crossed = crossed;
        r_d.irq     = crossed && !dma_mode_i;
        if (!dma_mode_i || !enable_i)      r_d.dma = 1'b0;
        else if (crossed && !r_q.crossed)  r_d.dma = 1'b1;
        else if (dma_ack_i)                r_d.dma = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_o     = r_q.irq;
    assign dma_req_o = r_q.dma;
endmodule

// File: rtl/pfe_ctrl.sv
module pfe_ctrl
    import pfe_pkg::*;
#(
    parameter int CS_W       = 3,
    parameter int NUM_WAIT   = 4,
    parameter int FIFO_DEPTH = 64,
    parameter int THR_W      = 7,
    localparam int WSEL_W = $clog2(NUM_WAIT),
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_write_mode,
    input  logic              cfg_sync_start,
    input  logic [WSEL_W-1:0] cfg_wait_sel,
    input  logic [CS_W-1:0]   cfg_cs_sel,
    input  logic              cfg_dma_mode,
    input  logic [THR_W-1:0]  cfg_threshold,
    input  logic              start,
    input  logic [NUM_WAIT-1:0] wait_pins,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              mem_ack,
    input  logic              dma_ack,
    output logic              mem_req,
    output logic              mem_write,
    output logic [CS_W-1:0]   cs_index,
    output logic              irq,
    output logic              dma_req
);
    typedef struct packed {
        pfe_state_e      state;
        logic [CS_W-1:0] cs;
        logic            wr;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic wait_fall;
    logic can_move;
    logic go;

    pfe_wait_sync #(.NUM_PINS(NUM_WAIT)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (wait_pins),
        .sel_i  (cfg_wait_sel),
        .fall_o (wait_fall)
    );

    pfe_thresh #(.DEPTH(FIFO_DEPTH), .THR_W(THR_W)) u_thr (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (cfg_enable),
        .write_mode_i (cfg_write_mode),
        .dma_mode_i   (cfg_dma_mode),
        .level_i      (fifo_level),
        .thr_i        (cfg_threshold),
        .dma_ack_i    (dma_ack),
        .irq_o        (irq),
        .dma_req_o    (dma_req)
    );

    always_comb begin
        fsm_d    = fsm_q;
        go       = cfg_enable && start;
        can_move = fsm_q.wr ? (fifo_level != '0)
                            : (fifo_level < LVL_W'(FIFO_DEPTH));
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (go) begin
                    fsm_d.cs    = cfg_cs_sel;
                    fsm_d.wr    = cfg_write_mode;
                    fsm_d.state = cfg_sync_start ? ST_ARM : ST_RUN;
                end
            end
            ST_ARM: begin
                if (!go)            fsm_d.state = ST_IDLE;
                else if (wait_fall) fsm_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (!go)           fsm_d.state = ST_IDLE;
                else if (can_move) fsm_d.state = ST_XFER;
            end
            ST_XFER: begin
                if (mem_ack) fsm_d.state = go ? ST_RUN : ST_IDLE;
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: ST_IDLE, cs: '0, wr: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign mem_req   = (fsm_q.state == ST_XFER);
    assign mem_write = fsm_q.wr;
    assign cs_index  = fsm_q.cs;
endmodule

// File: rtl/pfe_ctrl_chk.sv
module pfe_ctrl_chk #(
    parameter int CS_W       = 3,
    parameter int FIFO_DEPTH = 64,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             cfg_dma_mode,
    input logic [LVL_W-1:0] fifo_level,
    input logic             mem_ack,
    input logic             dma_ack,
    input logic             mem_req,
    input logic             mem_write,
    input logic [CS_W-1:0]  cs_index,
    input logic             irq,
    input logic             dma_req
);
    p_no_issue_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !mem_req) |=> !mem_req);

    p_full_blocks_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !mem_write && fifo_level == LVL_W'(FIFO_DEPTH)) |=> !mem_req);

    p_req_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    p_target_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(cs_index) && $stable(mem_write)));

    p_dma_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && cfg_dma_mode && cfg_enable) |=> dma_req);

    p_one_signal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));

    p_quiet_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!irq && !dma_req));
endmodule

bind pfe_ctrl pfe_ctrl_chk #(.CS_W(CS_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_dma_mode (cfg_dma_mode),
    .fifo_level   (fifo_level),
    .mem_ack      (mem_ack),
    .dma_ack      (dma_ack),
    .mem_req      (mem_req),
    .mem_write    (mem_write),
    .cs_index     (cs_index),
    .irq          (irq),
    .dma_req      (dma_req)
);

// File: tb/sim_pfe_ctrl.sv
`timescale 1ns/1ps
module sim_pfe_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 0, wmode = 0, sync = 0, dmam = 0, start = 0;
    logic [1:0] wsel = 0;
    logic [2:0] cssel = 0;
    logic [6:0] thr = 0;
    logic [3:0] pins = 0;
    logic [6:0] lvl = 0;
    logic       mack = 0, dack = 0;
    logic       mem_req, mem_write, irq, dma_req;
    logic [2:0] cs_index;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pfe_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_write_mode(wmode),
        .cfg_sync_start(sync), .cfg_wait_sel(wsel), .cfg_cs_sel(cssel),
        .cfg_dma_mode(dmam), .cfg_threshold(thr), .start(start),
        .wait_pins(pins), .fifo_level(lvl), .mem_ack(mack), .dma_ack(dack),
        .mem_req(mem_req), .mem_write(mem_write), .cs_index(cs_index),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIL? ");
        end
    endtask

    task automatic finish_xfer();
        mack = 1'b1;
        tick();
        mack = 1'b0;
    endtask

    task automatic to_idle();
        start = 1'b0;
        if (mem_req) finish_xfer();
        tick(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick();
        chk("R1 mem_req", mem_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 cs_index", cs_index, 0);
        chk("R1 mem_write", mem_write, 0);
    endtask

    task automatic t_immediate();
        en = 1; wmode = 0; sync = 0; cssel = 3'd5; lvl = 7'd10;
        start = 1;
        tick();
        chk("R3 no req after one edge", mem_req, 0);
        tick();
        chk("R3 req after two edges", mem_req, 1);
        chk("R5 cs latched", cs_index, 5);
        chk("R4 read direction", mem_write, 0);
        cssel = 3'd2;
        finish_xfer();
        chk("R13 req drops after ack", mem_req, 0);
        tick();
        chk("R3 next transfer", mem_req, 1);
        chk("R5 cs unchanged", cs_index, 5);
        tick(4);
        chk("R13 held without ack", mem_req, 1);
        en = 0;
        tick();
        chk("R2 transfer finishes", mem_req, 1);
        finish_xfer();
        chk("R2 idle after ack", mem_req, 0);
        tick(4);
        chk("R2 nothing while disabled", mem_req, 0);
        to_idle();
    endtask

    task automatic t_direction();
        en = 1; wmode = 1; lvl = 7'd0; cssel = 3'd7; start = 1;
        tick(4);
        chk("R4 empty FIFO blocks write", mem_req, 0);
        lvl = 7'd3;
        tick();
        chk("R4 write issued", mem_req, 1);
        chk("R4 write direction", mem_write, 1);
        chk("R5 cs seven", cs_index, 7);
        to_idle();
        wmode = 0; lvl = 7'd64; start = 1;
        tick(5);
        chk("R4 full FIFO blocks read", mem_req, 0);
        lvl = 7'd63;
        tick();
        chk("R4 read once room", mem_req, 1);
        to_idle();
    endtask

    task automatic t_sync();
        en = 1; sync = 1; wsel = 2'd2; wmode = 0; lvl = 7'd0;
        pins = 4'b0100;
        tick(4);
        pins = 4'b0000;
        tick(4);
        start = 1;
        tick(8);
        chk("R7 stale edge ignored", mem_req, 0);
        pins = 4'b0010;
        tick(4);
        pins = 4'b0000;
        tick(6);
        chk("R6 other pin ignored", mem_req, 0);
        pins = 4'b0100;
        tick(6);
        chk("R6 rising edge ignored", mem_req, 0);
        pins = 4'b0000;
        for (int i = 0; i < 8; i++) if (!mem_req) tick();
        chk("R6 selected falling edge starts", mem_req, 1);
        to_idle();
        sync = 0;
    endtask

    task automatic t_threshold();
        en = 1; dmam = 0; wmode = 0; thr = 7'd16; lvl = 7'd15;
        tick();
        chk("R8 below threshold", irq, 0);
        lvl = 7'd16;
        tick();
        chk("R8 at threshold", irq, 1);
        chk("R10 no dma in irq mode", dma_req, 0);
        wmode = 1; lvl = 7'd48;
        tick();
        chk("R9 free equals threshold", irq, 1);
        lvl = 7'd49;
        tick();
        chk("R9 free below threshold", irq, 0);
        thr = 7'd0; lvl = 7'd64;
        tick();
        chk("R9 zero threshold full FIFO", irq, 1);
        wmode = 0; thr = 7'd64; lvl = 7'd64;
        tick();
        chk("R8 threshold 64", irq, 1);
        en = 0;
        tick();
        chk("R12 irq low when disabled", irq, 0);
    endtask

    task automatic t_dma();
        en = 1; dmam = 1; wmode = 0; thr = 7'd8; lvl = 7'd0;
        tick(2);
        chk("R11 idle request", dma_req, 0);
        lvl = 7'd8;
        tick();
        chk("R11 raised on crossing", dma_req, 1);
        chk("R11 irq quiet in dma mode", irq, 0);
        tick(3);
        chk("R11 held until ack", dma_req, 1);
        dack = 1;
        tick();
        dack = 0;
        chk("R11 cleared by ack", dma_req, 0);
        tick(3);
        chk("R11 not raised while level stays", dma_req, 0);
        lvl = 7'd2;
        tick();
        lvl = 7'd9;
        tick();
        chk("R11 raised on new crossing", dma_req, 1);
        en = 0;
        tick();
        chk("R12 dma low when disabled", dma_req, 0);
        dmam = 0;
    endtask

    initial begin
        t_reset();
        t_immediate();
        t_direction();
        t_sync();
        t_threshold();
        t_dma();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule